// File: doc/BRIEF.md
# Streaming write allocation controller

This block sits beside a cache's write path and watches the sequence of incoming write requests. It recognises one sequential stream: a write whose start address equals the address just past the previous write extends the stream, and the total number of contiguous bytes is accumulated. As that total grows, the block moves through three named states. MODE_ALLOC is normal operation. MODE_COAL means writes should be merged before a whole-line request goes downstream. MODE_NOALLOC means writes are merged and the cache should not allocate a line for them.

The transitions are as follows. MODE_ALLOC goes to MODE_COAL when a contiguous write lifts the count above the coalesce byte limit. MODE_COAL goes to MODE_NOALLOC when a contiguous write lifts the count above the no-allocate byte limit. Any state returns to MODE_ALLOC on a write that breaks the stream. In every other case the state holds. Both limits are configured in lines and scaled by the line size.

Next to the state machine is a small table of per-line hold-back counters. While the block is coalescing, the first write to a line creates an entry loaded with a configurable count. A query asking whether a write miss to a line should be held back once more answers in the same cycle. A true answer uses up one count. A clear request removes a line's entry.

When a query, a clear and a write all arrive in one cycle, the table applies them in that order: query, then clear, then write.

Top module: `wr_stream_ctrl`

## Requirements
- R1: After reset the state is MODE_ALLOC (coalesce_o = 0, allocate_o = 1), the contiguous count is zero, the expected next address is zero, and every delay query answers 0.
- R2: coalesce_o is 0 only in MODE_ALLOC, and allocate_o is 0 only in MODE_NOALLOC. Neither output is ever 0 at the same time as the other.
- R3: A write is contiguous when wr_addr equals the expected next address. A contiguous write adds wr_size to the count. Every write sets the expected next address to wr_addr + wr_size.
- R4: MODE_ALLOC moves to MODE_COAL when the new count is strictly greater than COAL_LINES*LINE_BYTES. MODE_COAL moves to MODE_NOALLOC when the new count is strictly greater than NOALLOC_LINES*LINE_BYTES. A single write moves at most one state forward.
- R5: A non-contiguous write returns the block to MODE_ALLOC, sets the count to that write's size and restarts tracking from that write.
- R6: In MODE_NOALLOC the count saturates and is held, and contiguous writes keep the block in MODE_NOALLOC.
- R7: A write changes coalesce_o and allocate_o from the clock edge that samples it. Without a write, the outputs hold.
- R8: A write sampled while coalesce_o is 1, to a line without an entry, creates an entry holding DELAY_INIT (default 3). A write sampled while coalesce_o is 0 creates no entry.
- R9: A delay query to a line whose count is non-zero drives delay_o = 1 in the same cycle and decrements that count at the next edge. A query to a line whose count is zero, or that has no entry, drives delay_o = 0.
- R10: A clear request removes the entry of clr_line, so later queries to that line answer 0.
- R11: The table holds TBL_N (default 4) entries. Inserting into a full table replaces the entry that was inserted earliest among those still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A write request is presented this cycle |
| wr_addr | input | ADDR_W | Start byte address of the write |
| wr_size | input | SIZE_W | Write length in bytes |
| wr_line | input | LINE_W | Line address that the write falls in |
| qry_valid | input | 1 | Hold-back query strobe |
| qry_line | input | LINE_W | Line address being queried |
| clr_valid | input | 1 | Clear request strobe |
| clr_line | input | LINE_W | Line whose hold-back entry is removed |
| coalesce_o | output | 1 | Writes should be merged |
| allocate_o | output | 1 | Writes may allocate a line |
| delay_o | output | 1 | Queried write miss should be held back again |

## Verification
A corrupted state register or contiguous count shows up on coalesce_o and allocate_o at the edge after the write that crosses a limit, or when a stream breaks. The exact-limit boundary (count equal to the limit stays put) exposes an off-by-one in the comparison within one write. A wrong hold-back count or a missing entry appears on delay_o as soon as the line is queried. The order in which queries return 0 reveals a count that is not decremented. A wrong age ranking after a clear shows only when a later insertion into a full table evicts the wrong line, so that surviving and evicted lines are both queried.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
    typedef enum logic [1:0] {
        MODE_ALLOC   = 2'd0,
        MODE_COAL    = 2'd1,
        MODE_NOALLOC = 2'd2
    } wmode_e;
endpackage

// File: rtl/wsa_mode_fsm.sv
module wsa_mode_fsm
    import wsa_pkg::*;
#(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned SIZE_W        = 8,
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned LINE_BYTES    = 64,
    parameter int unsigned COAL_LINES    = 2,
    parameter int unsigned NOALLOC_LINES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    output logic              coalesce_o,
    output logic              allocate_o
);
    localparam logic [CNT_W-1:0] COAL_LIM = CNT_W'(COAL_LINES * LINE_BYTES);
    localparam logic [CNT_W-1:0] NA_LIM   = CNT_W'(NOALLOC_LINES * LINE_BYTES);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    wmode_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] next_q, next_d;
    logic [CNT_W:0]    sum;
    logic [CNT_W-1:0]  cnt_sat;
    logic              contig;

    assign contig  = (wr_addr == next_q);
    assign sum     = {1'b0, cnt_q} + (CNT_W+1)'(wr_size);
    assign cnt_sat = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];

    // next-state and stream tracking
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        next_d  = next_q;
        if (wr_valid) begin
            next_d = wr_addr + ADDR_W'(wr_size);
            if (!contig) begin
                state_d = MODE_ALLOC;
                cnt_d   = CNT_W'(wr_size);
            end else begin
                unique case (state_q)
                    MODE_ALLOC: begin
                        cnt_d = cnt_sat;
                        if (cnt_sat > COAL_LIM) state_d = MODE_COAL;
                    end
                    MODE_COAL: begin
                        cnt_d = cnt_sat;
                        if (cnt_sat > NA_LIM) state_d = MODE_NOALLOC;
                    end
                    MODE_NOALLOC: cnt_d = cnt_q;
                    default: state_d = MODE_ALLOC;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_ALLOC;
            cnt_q   <= '0;
            next_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            next_q  <= next_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            MODE_COAL:    begin coalesce_o = 1'b1; allocate_o = 1'b1; end
            MODE_NOALLOC: begin coalesce_o = 1'b1; allocate_o = 1'b0; end
            default:      begin coalesce_o = 1'b0; allocate_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/wsa_delay_table.sv
module wsa_delay_table #(
    parameter int unsigned LINE_W     = 26,
    parameter int unsigned TBL_N      = 4,
    parameter int unsigned DLY_W      = 4,
    parameter int unsigned DELAY_INIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [LINE_W-1:0] ins_line,
    input  logic              qry_valid,
    input  logic [LINE_W-1:0] qry_line,
    input  logic              clr_valid,
    input  logic [LINE_W-1:0] clr_line,
    output logic              delay_o
);
    localparam int unsigned AGE_W = (TBL_N > 1) ? $clog2(TBL_N) : 1;
    localparam logic [AGE_W-1:0] AGE_OLD = AGE_W'(TBL_N - 1);

    logic [TBL_N-1:0]  vld_q, vld_d;
    logic [LINE_W-1:0] line_q [TBL_N];
    logic [LINE_W-1:0] line_d [TBL_N];
    logic [DLY_W-1:0]  cnt_q  [TBL_N];
    logic [DLY_W-1:0]  cnt_d  [TBL_N];
    logic [AGE_W-1:0]  age_q  [TBL_N];
    logic [AGE_W-1:0]  age_d  [TBL_N];
    logic [TBL_N-1:0]  qhit, live;

    for (genvar g = 0; g < TBL_N; g++) begin : g_look
        assign qhit[g] = vld_q[g] && (line_q[g] == qry_line);
        assign live[g] = (cnt_q[g] != '0);
    end

    assign delay_o = qry_valid && |(qhit & live);

    logic             clr_hit, ins_hit, free_any;
    logic [AGE_W-1:0] clr_age;
    int unsigned      slot;

    // query, then clear, then insert
    always_comb begin
        vld_d    = vld_q;
        line_d   = line_q;
        cnt_d    = cnt_q;
        age_d    = age_q;
        clr_hit  = 1'b0;
        clr_age  = '0;
        ins_hit  = 1'b0;
        free_any = 1'b0;
        slot     = 0;
        for (int i = 0; i < TBL_N; i++) begin
            if (qry_valid && qhit[i] && live[i]) cnt_d[i] = cnt_q[i] - DLY_W'(1);
        end
        if (clr_valid) begin
            for (int i = 0; i < TBL_N; i++) begin
                if (vld_d[i] && line_d[i] == clr_line) begin
                    clr_hit  = 1'b1;
                    clr_age  = age_d[i];
                    vld_d[i] = 1'b0;
                end
            end
            for (int i = 0; i < TBL_N; i++) begin
                if (clr_hit && vld_d[i] && age_d[i] > clr_age) age_d[i] = age_d[i] - AGE_W'(1);
            end
        end
        if (ins_valid) begin
            for (int i = 0; i < TBL_N; i++) begin
                if (vld_d[i] && line_d[i] == ins_line) ins_hit = 1'b1;
            end
            for (int i = TBL_N - 1; i >= 0; i--) begin
                if (!vld_d[i]) begin
                    free_any = 1'b1;
                    slot     = i;
                end
            end
            if (!free_any) begin
                for (int i = 0; i < TBL_N; i++) begin
                    if (age_d[i] == AGE_OLD) slot = i;
                end
            end
            if (!ins_hit) begin
                for (int i = 0; i < TBL_N; i++) begin
                    if (vld_d[i] && i != slot) age_d[i] = age_d[i] + AGE_W'(1);
                end
                vld_d[slot]  = 1'b1;
                line_d[slot] = ins_line;
                cnt_d[slot]  = DLY_W'(DELAY_INIT);
                age_d[slot]  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < TBL_N; i++) begin
                line_q[i] <= '0;
                cnt_q[i]  <= '0;
                age_q[i]  <= '0;
            end
        end else begin
            vld_q  <= vld_d;
            line_q <= line_d;
            cnt_q  <= cnt_d;
            age_q  <= age_d;
        end
    end
endmodule

// File: rtl/wr_stream_ctrl.sv
module wr_stream_ctrl #(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned SIZE_W        = 8,
    parameter int unsigned LINE_BYTES    = 64,
    parameter int unsigned LINE_W        = ADDR_W - $clog2(LINE_BYTES),
    parameter int unsigned COAL_LINES    = 2,
    parameter int unsigned NOALLOC_LINES = 4,
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned TBL_N         = 4,
    parameter int unsigned DLY_W         = 4,
    parameter int unsigned DELAY_INIT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              qry_valid,
    input  logic [LINE_W-1:0] qry_line,
    input  logic              clr_valid,
    input  logic [LINE_W-1:0] clr_line,
    output logic              coalesce_o,
    output logic              allocate_o,
    output logic              delay_o
);
    logic ins_valid;

    assign ins_valid = wr_valid && coalesce_o;

    wsa_mode_fsm #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W),
        .LINE_BYTES(LINE_BYTES), .COAL_LINES(COAL_LINES),
        .NOALLOC_LINES(NOALLOC_LINES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_size(wr_size),
        .coalesce_o(coalesce_o), .allocate_o(allocate_o)
    );

    wsa_delay_table #(
        .LINE_W(LINE_W), .TBL_N(TBL_N), .DLY_W(DLY_W), .DELAY_INIT(DELAY_INIT)
    ) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_line(wr_line),
        .qry_valid(qry_valid), .qry_line(qry_line),
        .clr_valid(clr_valid), .clr_line(clr_line),
        .delay_o(delay_o)
    );
endmodule

// File: rtl/wsa_checker.sv
module wsa_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic qry_valid,
    input logic coalesce_o,
    input logic allocate_o,
    input logic delay_o
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |-> (!coalesce_o && allocate_o));

    assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !allocate_o |-> coalesce_o);

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!coalesce_o) |-> allocate_o);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_valid) |-> ($stable(coalesce_o) && $stable(allocate_o)));

    assert_delay_by_query_R9: assert property (@(posedge clk) disable iff (!rst_n)
        delay_o |-> qry_valid);
endmodule

bind wr_stream_ctrl wsa_checker u_chk (.*);

// File: tb/sim_wr_stream_ctrl.sv
`timescale 1ns/1ps
module sim_wr_stream_ctrl;
    localparam int COAL_B = 128;
    localparam int NA_B   = 256;
    localparam int CMAX   = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [7:0]  wr_size = '0;
    logic [25:0] wr_line = '0;
    logic        qry_valid = 1'b0;
    logic [25:0] qry_line = '0;
    logic        clr_valid = 1'b0;
    logic [25:0] clr_line = '0;
    logic        coalesce_o, allocate_o, delay_o;

    wr_stream_ctrl u0 (.*);

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    kind;
        int    due;
        logic  e0;
        logic  e1;
        string tag;
    } item_t;
    item_t exp_q[$];

    int n_cmp = 0;
    int n_bad = 0;

    int m = 0;
    int cnt = 0;
    longint nxt = 0;
    int tl[$];
    int tc[$];

    initial forever begin
        @(negedge clk);
        #1;
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            item_t it;
            it = exp_q.pop_front();
            n_cmp++;
            if (it.kind == 0) begin
                if (coalesce_o !== it.e0 || allocate_o !== it.e1) begin
                    n_bad++;
                    $display("FAIL %s: coalesce/allocate got %b%b expected %b%b",
                             it.tag, coalesce_o, allocate_o, it.e0, it.e1);
                end
            end else begin
                if (delay_o !== it.e0) begin
                    n_bad++;
                    $display("FAIL %s: delay got %b expected %b", it.tag, delay_o, it.e0);
                end
            end
        end
    end

    task automatic push(input int kind, input int due, input logic a, input logic b, input string tag);
        item_t it;
        it.kind = kind; it.due = due; it.e0 = a; it.e1 = b; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic model_insert(input int line);
        int hit = 0;
        foreach (tl[i]) if (tl[i] == line) hit = 1;
        if (!hit) begin
            if (tl.size() == 4) begin
                void'(tl.pop_front());
                void'(tc.pop_front());
            end
            tl.push_back(line);
            tc.push_back(3);
        end
    endtask

    task automatic do_write(input longint a, input int sz, input string tag, input bit pre);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 32'(a); wr_size = 8'(sz); wr_line = 26'(a / 64);
        if (pre) push(0, cyc, m != 0, m != 2, {tag, " before edge"});
        if (m != 0) model_insert(int'(a / 64));
        if (a == nxt) begin
            if (m == 0) begin
                cnt = (cnt + sz > CMAX) ? CMAX : cnt + sz;
                if (cnt > COAL_B) m = 1;
            end else if (m == 1) begin
                cnt = (cnt + sz > CMAX) ? CMAX : cnt + sz;
                if (cnt > NA_B) m = 2;
            end
        end else begin
            m = 0;
            cnt = sz;
        end
        nxt = a + sz;
        push(0, cyc + 1, m != 0, m != 2, tag);
        @(posedge clk);
        #1 wr_valid = 1'b0;
    endtask

    task automatic do_query(input int line, input string tag);
        logic e = 1'b0;
        @(negedge clk);
        qry_valid = 1'b1; qry_line = 26'(line);
        foreach (tl[i]) if (tl[i] == line && tc[i] > 0) begin e = 1'b1; tc[i]--; end
        push(1, cyc, e, 1'b0, tag);
        @(posedge clk);
        #1 qry_valid = 1'b0;
    endtask

    task automatic do_clear(input int line);
        @(negedge clk);
        clr_valid = 1'b1; clr_line = 26'(line);
        for (int i = tl.size() - 1; i >= 0; i--) if (tl[i] == line) begin
            tl.delete(i); tc.delete(i);
        end
        @(posedge clk);
        #1 clr_valid = 1'b0;
    endtask

    bit finished = 0;

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        push(0, cyc, 1'b0, 1'b1, "R1 reset mode");
        do_query(0, "R1 reset delay");
        // contiguous stream from address zero
        for (int k = 0; k < 4; k++) do_write(32 * k, 32, "R3 contiguous at or below limit", 0);
        do_write(128, 32, "R4 alloc to coalesce", 0);
        do_write(160, 32, "R8 coalescing write", 0);
        do_write(192, 32, "R8 coalescing write", 0);
        do_write(224, 32, "R4 equal to no-alloc limit stays", 0);
        do_write(256, 32, "R4 coalesce to no-alloc", 0);
        do_write(288, 32, "R6 no-alloc holds", 0);
        do_write(320, 32, "R6 no-alloc holds", 0);
        do_write(352, 32, "R2 no-alloc outputs", 0);
        do_write(384, 32, "R11 insert into full table", 0);
        do_query(2, "R11 oldest evicted");
        do_query(3, "R9 count 3");
        do_query(3, "R9 count 2");
        do_query(3, "R9 count 1");
        do_query(3, "R9 exhausted");
        do_query(9, "R9 no entry");
        do_clear(4);
        do_query(4, "R10 cleared line");
        do_write(416, 32, "R6 no-alloc holds", 0);
        do_write(448, 32, "R8 new line after clear", 0);
        do_write(480, 32, "R6 no-alloc holds", 0);
        do_write(512, 32, "R11 replace after clear", 0);
        do_query(3, "R11 oldest evicted after clear");
        do_query(5, "R11 younger survives");
        repeat (3) @(negedge clk);
        push(0, cyc, 1'b1, 1'b0, "R7 idle holds");
        // break the stream
        do_write(1000, 64, "R5 non-contiguous restart", 1);
        do_write(1064, 64, "R4 count equal to coalesce limit", 0);
        do_query(16, "R8 no entry in alloc mode");
        do_write(1128, 1, "R4 one byte over limit", 0);
        do_write(1129, 8, "R8 entry created while coalescing", 0);
        do_query(17, "R8 fresh entry");
        do_query(15, "R8 entry from earlier write");
        repeat (4) @(negedge clk);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule